// File: doc/BRIEF.md
# Asynchronous SRAM Module Controller

This block lets a clocked host read and write a static RAM module that has no clock. The module holds two ranks of byte-wide chips, 512K words per rank, on a shared 32-bit data bus. It has four active-low chip selects, one write strobe and one output strobe. The host presents a request (read or write, address, write data, organisation) and gets back a one-cycle ready pulse when the access has finished. Read data comes back with that pulse.

At run time the host chooses between two organisations. In word mode the module looks like 1M x 32, and one rank answers with both half-word lanes. In half-word mode it looks like 2M x 16, with one chip select at a time and 16-bit read data returned right-justified. The lengths of the write pulse, the read window and the bus turnaround are cycle counts. They are worked out at elaboration from nanosecond timing parameters and the clock period, and each is at least one cycle.

The data bus is split into a drive value, a drive enable and a sampled input, so the tri-state buffer itself sits at the pad. The controller never drives the bus while the memory may be driving it.

Top module: `sram_mod_ctl`

## Requirements
- R1: After reset, and while idle, every chip select is high (`mem_cs_n` = 4'b1111), `mem_we_n` and `mem_oe_n` are high, `mem_dq_oe` is 0 and `rsp_rdy` is 0. A reset in the middle of an access returns the memory pins to this state.
- R2: In word mode (`mode16` = 0), `req_addr[19]` picks the rank and `req_addr[18:0]` goes to `mem_addr`. `req_addr[20]` is ignored. Rank 0 gives `mem_cs_n` = 4'b1100 and rank 1 gives 4'b0011, where `mem_cs_n[i]` is chip select i+1. The two selects of a rank are never split.
- R3: In half-word mode (`mode16` = 1), `req_addr[20]` picks the rank, `req_addr[0]` picks the lane (0 = bits 15:0, 1 = bits 31:16) and `req_addr[19:1]` goes to `mem_addr`. Exactly one select is low: 4'b1110 (rank 0, low lane), 4'b1101 (rank 0, high lane), 4'b1011 (rank 1, low lane) or 4'b0111 (rank 1, high lane).
- R4: A write holds `mem_we_n` low, `mem_oe_n` high and `mem_dq_oe` at 1, with the selects stable, for exactly WR_CYC cycles. WR_CYC is the largest of the write pulse, write cycle and data setup times rounded up to whole clocks; it is 2 at the defaults. Selects, strobe and drive enable are all released on the edge that raises `rsp_rdy`.
- R5: In word mode the drive value is `req_wdata`. In half-word mode the drive value is `req_wdata[15:0]` copied onto both halves of `mem_dq_o`, and `req_wdata[31:16]` has no effect.
- R6: A read holds `mem_oe_n` low, `mem_we_n` high and `mem_dq_oe` at 0 for RD_CYC cycles. RD_CYC is the larger of the access time and read cycle time rounded up to whole clocks; it is 2 at the defaults. `mem_dq_i` is captured into `rsp_rdata` on the edge that raises `rsp_rdy`. In word mode `rsp_rdata` is `mem_dq_i` unchanged.
- R7: In half-word mode `rsp_rdata[15:0]` is the selected lane and `rsp_rdata[31:16]` is zero.
- R8: A write accepted after a read first spends TURN_CYC cycles fully deselected (TURN_CYC is the bus release time rounded up to whole clocks, minimum one; it is 1 at the defaults). Its ready then comes TURN_CYC cycles later than a plain write's.
- R9: `rsp_rdy` is high for a single cycle per access. A request is accepted only while idle: changes to the request inputs during an access leave the memory pins and the returned data unchanged. The settings of `req_addr`, `req_write`, `req_wdata` and `mode16` are captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode16 | input | 1 | 1 = 2M x 16 organisation, 0 = 1M x 32 |
| req_valid | input | 1 | Request present; accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Host address (bit 20 used only in half-word mode) |
| req_wdata | input | 32 | Write data |
| rsp_rdy | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_rdy after a read |
| mem_addr | output | 19 | Word address to both ranks |
| mem_cs_n | output | 4 | Active-low chip selects, bit i = select i+1 |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_o | output | 32 | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 32 | Data bus sampled value |

## Verification
Several rules are checked on every cycle:
- the select pattern is always a legal one;
- the controller never drives the bus while the output strobe is low;
- the write strobe is only low with a select active and the drivers on;
- each write strobe pulse lasts exactly WR_CYC cycles;
- the cycle before a write pulse begins has the output strobe off;
- ready never stays high for two cycles.

The bench scenarios are needed for the rest:
- the address and lane decode in each mode;
- lane copying and right-justified return, checked against a half-word memory model;
- the latencies, including the extra turnaround after a read;
- that requests are ignored while busy;
- reset in the middle of an access.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_TURN = 2'd2,
        ST_WR   = 2'd3
    } seq_st_e;

    // whole clock cycles covering t_ns, never fewer than one
    function automatic int cyc_of(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_dec.sv
`timescale 1ns/1ps
module sram_lane_dec #(
    parameter int WORD_AW = 19
) (
    input  logic               mode16,
    input  logic [WORD_AW+1:0] addr,
    output logic [WORD_AW-1:0] word,
    output logic [3:0]         cs_n,
    output logic               lane
);
    logic rank;

    assign rank = mode16 ? addr[WORD_AW+1] : addr[WORD_AW];
    assign lane = mode16 & addr[0];
    assign word = mode16 ? addr[WORD_AW:1] : addr[WORD_AW-1:0];

    // select g belongs to rank g/2 and lane g%2
    for (genvar g = 0; g < 4; g++) begin : g_sel
        localparam logic SEL_RANK = ((g / 2) == 1);
        localparam logic SEL_LANE = ((g % 2) == 1);
        assign cs_n[g] = !((rank == SEL_RANK) && (!mode16 || (lane == SEL_LANE)));
    end
endmodule

// File: rtl/sram_data_steer.sv
`timescale 1ns/1ps
module sram_data_steer #(
    parameter int DATA_W = 32
) (
    input  logic              mode16,
    input  logic              lane,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_drv,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] half;

    assign dq_drv = mode16 ? {2{wdata[HALF_W-1:0]}} : wdata;
    assign half   = lane ? dq_i[DATA_W-1:HALF_W] : dq_i[HALF_W-1:0];
    assign rdata  = mode16 ? {{HALF_W{1'b0}}, half} : dq_i;
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int WORD_AW  = 19,
    parameter int DATA_W   = 32,
    parameter int WR_CYC   = 2,
    parameter int RD_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_mode16,
    input  logic [WORD_AW+1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               src_mode16,
    output logic [WORD_AW+1:0] src_addr,
    output logic [DATA_W-1:0]  src_wdata,
    input  logic [WORD_AW-1:0] dec_word,
    input  logic [3:0]         dec_cs_n,
    input  logic [DATA_W-1:0]  drv_data,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [WORD_AW-1:0] mem_addr,
    output logic [3:0]         mem_cs_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe,
    output logic               rsp_rdy,
    output logic [DATA_W-1:0]  rsp_rdata
);
    localparam int MAX_CYC = max2(max2(WR_CYC, RD_CYC), TURN_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        seq_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic               rd_last;
        logic               p_mode16;
        logic [WORD_AW+1:0] p_addr;
        logic [DATA_W-1:0]  p_wdata;
        logic [3:0]         cs_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
        logic [WORD_AW-1:0] maddr;
        logic [DATA_W-1:0]  dq_o;
        logic               rdy;
        logic [DATA_W-1:0]  rdata;
    } seq_r_t;

    function automatic seq_r_t rst_val();
        seq_r_t r;
        r      = '0;
        r.st   = ST_IDLE;
        r.cs_n = 4'b1111;
        r.we_n = 1'b1;
        r.oe_n = 1'b1;
        return r;
    endfunction

    seq_r_t q, d;

    // decode follows the live request while idle, the captured one after
    assign src_mode16 = (q.st == ST_IDLE) ? req_mode16 : q.p_mode16;
    assign src_addr   = (q.st == ST_IDLE) ? req_addr   : q.p_addr;
    assign src_wdata  = (q.st == ST_IDLE) ? req_wdata  : q.p_wdata;

    always_comb begin
        logic go_wr;
        logic go_rd;
        go_wr = 1'b0;
        go_rd = 1'b0;
        d     = q;
        d.rdy = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.p_mode16 = req_mode16;
                    d.p_addr   = req_addr;
                    d.p_wdata  = req_wdata;
                    if (req_write && q.rd_last) begin
                        d.st  = ST_TURN;
                        d.cnt = CNT_W'(TURN_CYC - 1);
                    end else if (req_write) begin
                        go_wr = 1'b1;
                    end else begin
                        go_rd = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (q.cnt == '0) go_wr = 1'b1;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_WR: begin
                if (q.cnt == '0) begin
                    d.st    = ST_IDLE;
                    d.cs_n  = 4'b1111;
                    d.we_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    d.rdy   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RD: begin
                if (q.cnt == '0) begin
                    d.st    = ST_IDLE;
                    d.cs_n  = 4'b1111;
                    d.oe_n  = 1'b1;
                    d.rdata = rd_data;
                    d.rdy   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d = rst_val();
        endcase
        if (go_wr) begin
            d.st      = ST_WR;
            d.cnt     = CNT_W'(WR_CYC - 1);
            d.cs_n    = dec_cs_n;
            d.maddr   = dec_word;
            d.we_n    = 1'b0;
            d.oe_n    = 1'b1;
            d.dq_oe   = 1'b1;
            d.dq_o    = drv_data;
            d.rd_last = 1'b0;
        end
        if (go_rd) begin
            d.st      = ST_RD;
            d.cnt     = CNT_W'(RD_CYC - 1);
            d.cs_n    = dec_cs_n;
            d.maddr   = dec_word;
            d.we_n    = 1'b1;
            d.oe_n    = 1'b0;
            d.dq_oe   = 1'b0;
            d.rd_last = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rst_val();
        else        q <= d;
    end

    assign mem_addr  = q.maddr;
    assign mem_cs_n  = q.cs_n;
    assign mem_we_n  = q.we_n;
    assign mem_oe_n  = q.oe_n;
    assign mem_dq_o  = q.dq_o;
    assign mem_dq_oe = q.dq_oe;
    assign rsp_rdy   = q.rdy;
    assign rsp_rdata = q.rdata;

    // strobe length monitor for the pulse width check
    logic [CNT_W:0] wlen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      wlen_q <= '0;
        else if (!q.we_n && !(&wlen_q))  wlen_q <= wlen_q + 1'b1;
        else if (q.we_n)                 wlen_q <= '0;
    end

    // R4
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.we_n) |-> (wlen_q == (CNT_W+1)'(WR_CYC)));

    // R6
    no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.oe_n |-> !q.dq_oe);

    // R4
    write_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.we_n |-> (q.dq_oe && q.oe_n && (q.cs_n != 4'b1111)));

    // R2
    rank_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~q.cs_n) >= 2) |-> ((q.cs_n == 4'b1100) || (q.cs_n == 4'b0011)));

    // R8
    quiet_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.we_n) |-> ($past(q.oe_n) && ($past(q.cs_n) == 4'b1111)));

    // R9
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |=> !q.rdy);
endmodule

// File: rtl/sram_mod_ctl.sv
`timescale 1ns/1ps
module sram_mod_ctl
    import sram_ctl_pkg::*;
#(
    parameter int WORD_AW = 19,
    parameter int DATA_W  = 32,
    parameter int CLK_NS  = 10,
    parameter int T_WP_NS = 12,
    parameter int T_WC_NS = 15,
    parameter int T_DW_NS = 8,
    parameter int T_AA_NS = 15,
    parameter int T_RC_NS = 15,
    parameter int T_HZ_NS = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode16,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [WORD_AW+1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_rdy,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [WORD_AW-1:0] mem_addr,
    output logic [3:0]         mem_cs_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_i
);
    localparam int WR_CYC   = max2(max2(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_WC_NS, CLK_NS)),
                                   cyc_of(T_DW_NS, CLK_NS));
    localparam int RD_CYC   = max2(cyc_of(T_AA_NS, CLK_NS), cyc_of(T_RC_NS, CLK_NS));
    localparam int TURN_CYC = cyc_of(T_HZ_NS, CLK_NS);

    logic               src_mode16;
    logic [WORD_AW+1:0] src_addr;
    logic [DATA_W-1:0]  src_wdata;
    logic [WORD_AW-1:0] dec_word;
    logic [3:0]         dec_cs_n;
    logic               dec_lane;
    logic [DATA_W-1:0]  drv_data;
    logic [DATA_W-1:0]  rd_data;

    sram_lane_dec #(.WORD_AW(WORD_AW)) dec_i (
        .mode16 (src_mode16),
        .addr   (src_addr),
        .word   (dec_word),
        .cs_n   (dec_cs_n),
        .lane   (dec_lane)
    );

    sram_data_steer #(.DATA_W(DATA_W)) steer_i (
        .mode16 (src_mode16),
        .lane   (dec_lane),
        .wdata  (src_wdata),
        .dq_i   (mem_dq_i),
        .dq_drv (drv_data),
        .rdata  (rd_data)
    );

    sram_seq_fsm #(
        .WORD_AW  (WORD_AW),
        .DATA_W   (DATA_W),
        .WR_CYC   (WR_CYC),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_mode16 (mode16),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .src_mode16 (src_mode16),
        .src_addr   (src_addr),
        .src_wdata  (src_wdata),
        .dec_word   (dec_word),
        .dec_cs_n   (dec_cs_n),
        .drv_data   (drv_data),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_oe  (mem_dq_oe),
        .rsp_rdy    (rsp_rdy),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: tb/sram_mod_ctl_tb.sv
`timescale 1ns/1ps
module sram_mod_ctl_tb_top;
    // expected cycle counts at the default timing (R4, R6, R8)
    localparam int WR_EXP   = 2;
    localparam int RD_EXP   = 2;
    localparam int TURN_EXP = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode16 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_rdy;
    logic [31:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_i;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sram_mod_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .mode16(mode16), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdy(rsp_rdy), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // half-word memory model: select i serves lane i%2 of rank i/2
    logic [15:0] hw_m [4][16];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 16; j++) hw_m[i][j] <= 16'h0;
        end else if (!mem_we_n && mem_dq_oe) begin
            for (int i = 0; i < 4; i++)
                if (!mem_cs_n[i])
                    hw_m[i][mem_addr[3:0]] <= (i % 2 == 1) ? mem_dq_o[31:16] : mem_dq_o[15:0];
        end
    end

    always_comb begin
        logic [15:0] lo, hi;
        lo = 16'h5A5A;
        hi = 16'h5A5A;
        if (!mem_oe_n && mem_we_n) begin
            if (!mem_cs_n[0]) lo = hw_m[0][mem_addr[3:0]];
            if (!mem_cs_n[2]) lo = hw_m[2][mem_addr[3:0]];
            if (!mem_cs_n[1]) hi = hw_m[1][mem_addr[3:0]];
            if (!mem_cs_n[3]) hi = hw_m[3][mem_addr[3:0]];
        end
        mem_dq_i = {hi, lo};
    end

    typedef struct packed {
        logic        m16;
        logic        wr;
        logic [20:0] addr;
        logic [31:0] wd;
        logic [3:0]  cs;
        logic [18:0] ma;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 21'h000003, 32'h11223344, 4'b1100, 19'h3, 32'h0},
        '{1'b0, 1'b1, 21'h080005, 32'hA5A55A5A, 4'b0011, 19'h5, 32'h0},
        '{1'b0, 1'b0, 21'h000003, 32'h0,        4'b1100, 19'h3, 32'h11223344},
        '{1'b0, 1'b0, 21'h080005, 32'h0,        4'b0011, 19'h5, 32'hA5A55A5A},
        '{1'b1, 1'b1, 21'h000008, 32'hFFFFBEEF, 4'b1110, 19'h4, 32'h0},
        '{1'b1, 1'b1, 21'h000009, 32'h7777CAFE, 4'b1101, 19'h4, 32'h0},
        '{1'b1, 1'b0, 21'h000009, 32'h0,        4'b1101, 19'h4, 32'h0000CAFE},
        '{1'b1, 1'b0, 21'h000008, 32'h0,        4'b1110, 19'h4, 32'h0000BEEF},
        '{1'b0, 1'b0, 21'h000004, 32'h0,        4'b1100, 19'h4, 32'hCAFEBEEF},
        '{1'b1, 1'b1, 21'h100007, 32'h00001234, 4'b0111, 19'h3, 32'h0},
        '{1'b1, 1'b0, 21'h100007, 32'h0,        4'b0111, 19'h3, 32'h00001234},
        '{1'b0, 1'b0, 21'h180003, 32'h0,        4'b0011, 19'h3, 32'h12340000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " cs_n"}, 32'(mem_cs_n), 32'hF);
        chk({tag, " we_n"}, 32'(mem_we_n), 32'h1);
        chk({tag, " oe_n"}, 32'(mem_oe_n), 32'h1);
        chk({tag, " dq_oe"}, 32'(mem_dq_oe), 32'h0);
    endtask

    bit prev_rd = 1'b0;

    task automatic run_vec(input vec_t v);
        int cyc, first, wlow;
        bit got, seen, turn;
        logic [3:0] s_cs; logic [18:0] s_ma; logic s_we, s_oe, s_dqoe; logic [31:0] s_dq;
        string dtag;
        turn = v.wr && prev_rd;
        dtag = v.m16 ? "R3" : "R2";
        cyc = 0; first = 0; wlow = 0; got = 0; seen = 0;
        s_cs = '1; s_ma = '0; s_we = 1; s_oe = 1; s_dqoe = 0; s_dq = '0;
        @(negedge clk);
        mode16 = v.m16; req_write = v.wr; req_addr = v.addr; req_wdata = v.wd; req_valid = 1'b1;
        while (!got && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) req_valid = 1'b0;
            if (!mem_we_n) wlow++;
            if (!seen && mem_cs_n != 4'hF) begin
                seen = 1; first = cyc;
                s_cs = mem_cs_n; s_ma = mem_addr; s_we = mem_we_n; s_oe = mem_oe_n;
                s_dqoe = mem_dq_oe; s_dq = mem_dq_o;
            end
            if (rsp_rdy) got = 1;
        end
        chk({dtag, " select pattern"}, 32'(s_cs), 32'(v.cs));
        chk({dtag, " word address"}, 32'(s_ma), 32'(v.ma));
        if (v.wr) begin
            chk("R8 first active cycle", first, turn ? 1 + TURN_EXP : 1);
            chk("R8 write latency", cyc, WR_EXP + 1 + (turn ? TURN_EXP : 0));
            chk("R4 strobe low cycles", wlow, WR_EXP);
            chk("R4 strobes during write", {29'b0, s_we, s_oe, s_dqoe}, 32'h3 & 32'b011);
            chk("R5 drive value", s_dq, v.m16 ? {v.wd[15:0], v.wd[15:0]} : v.wd);
        end else begin
            chk("R6 read latency", cyc, RD_EXP + 1);
            chk("R6 strobes during read", {29'b0, s_we, s_oe, s_dqoe}, 32'b100);
            chk(v.m16 ? "R7 read data" : "R6 read data", rsp_rdata, v.rd);
        end
        check_idle(v.wr ? "R4 release" : "R6 release");
        @(negedge clk);
        chk("R9 ready one cycle", 32'(rsp_rdy), 32'h0);
        prev_rd = !v.wr;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        chk("R1 reset rdy", 32'(rsp_rdy), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle");

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9: request inputs changed during a read are ignored
        begin
            int cyc; bit got;
            cyc = 0; got = 0;
            @(negedge clk);
            mode16 = 1'b0; req_write = 1'b0; req_addr = 21'h000003; req_wdata = '0; req_valid = 1'b1;
            while (!got && cyc < 40) begin
                @(negedge clk);
                cyc++;
                if (cyc == 1) begin
                    req_addr = 21'h080005; req_write = 1'b1; req_wdata = 32'hDEADDEAD; mode16 = 1'b1;
                end
                if (cyc == 2) begin
                    chk("R9 address held", 32'(mem_addr), 32'h3);
                    chk("R9 select held", 32'(mem_cs_n), 32'hC);
                    chk("R9 no write started", 32'(mem_we_n), 32'h1);
                end
                if (rsp_rdy) begin got = 1; req_valid = 1'b0; end
            end
            chk("R9 latency unchanged", cyc, RD_EXP + 1);
            chk("R9 read data", rsp_rdata, 32'h11223344);
            @(negedge clk);
            chk("R9 word unchanged by ignored write", {hw_m[1][3], hw_m[0][3]}, 32'h11223344);
        end

        // R1: reset in the middle of a write
        @(negedge clk);
        mode16 = 1'b0; req_write = 1'b1; req_addr = 21'h000002; req_wdata = 32'h0F0F0F0F; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-access reset");
        chk("R1 mid-access rdy", 32'(rsp_rdy), 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule